// File: doc/BRIEF.md
# Random Number Generator Control Front End

This block is the register-mapped face of a random number source. Software writes a command word to start either a self test or a seeding run. A small sequencer carries the operation out in a fixed number of cycles and then raises a done flag. A seeding run can fail statistically, and that failure sets a bit in an error register. One interrupt line reports done and error conditions, and each of the two sources can be masked on its own. After a successful seed, a pseudo-random generator fills a 16-word output queue. Software drains the queue through a data register.

The generator is a 32-bit shift-register stand-in that is loaded from an entropy test input. A second test input forces the statistical failure, so that the retry-and-clear path software relies on can be exercised. When automatic reseeding is enabled, the block counts the words software has taken out. It reseeds on its own after a fixed number of 160-bit blocks.

Registers are decoded on word addresses: bits 1:0 of the address are ignored. Reads are combinational from the current state. A read of the data register pops one word at the clock edge that ends the read cycle.

Top module: `randgen_ctrl`

## Requirements
- R1: Word index 0 (byte 0x00) reads as the type in bits 31:28, the major revision in bits 15:8 and the minor revision in bits 7:0, taken from the parameters VER_TYPE, VER_MAJ and VER_MIN. All other bits read zero.
- R2: Writing the command register (byte 0x04) with bit 0 set starts a self test, and bit 1 set starts seeding; if both are set, only the self test starts. A self test sets the status (byte 0x0C) bit 4 ST_CYCLES clock edges after the write edge. A seeding run sets status bit 5 SEED_CYCLES edges after. Both flags stay set until cleared.
- R3: A start command written while an operation is running is ignored. It starts nothing and sets no flag.
- R4: If force_stat_err is high when a seeding run finishes, then bit 3 of the error register (byte 0x10) and status bit 16 are set, and the generator stops producing words until a later seed succeeds.
- R5: Command bit 4 clears both done flags only when the error register is zero. While an error is present it changes nothing.
- R6: Command bit 5 clears the error register and both done flags when an error is present. With no error present it changes nothing.
- R7: The control register (byte 0x08) holds automatic reseed in bit 4, the done mask in bit 5 and the error mask in bit 6, and reads back what was written. irq is high exactly when (a done flag is set and bit 5 is 0) or (an error is present and bit 6 is 0).
- R8: A successful seed loads the generator state S with entropy_in, or with 1 if entropy_in is zero. Each word the generator produces is S' = {0, S[31:1]} XOR (S[0] ? 0x80200003 : 0), and S' becomes the new state. Words are produced, one per cycle, while the queue has room and no operation runs. They are read out in order at byte 0x14.
- R9: The queue holds FIFO_DEPTH = 16 words. Status bits 11:8 show the fill level, saturated at 15.
- R10: A data read with the queue empty returns zero and leaves the level at zero.
- R11: With automatic reseed enabled, the data read that takes out word number RESEED_BLOCKS*5 since the last reseed (counting only reads made while enabled) starts a seeding run. That run loads entropy_in and sets status bit 5. Words already queued are kept and are read before the new ones.
- R12: After reset, the control, status and error registers read zero, irq is low and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; a data register read pops a word |
| bus_addr | input | ADDR_W | Byte address, decoded on bits ADDR_W-1:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| entropy_in | input | 32 | Test entropy value loaded on a successful seed |
| force_stat_err | input | 1 | Test input forcing a statistical failure when seeding ends |
| irq | output | 1 | Maskable done or error interrupt |

## Verification
The bench builds the block with ST_CYCLES = 40, SEED_CYCLES = 12 and RESEED_BLOCKS = 2. With these values a whole self test is long enough to drain all 16 queued words while generation is paused, which shows the true depth behind the saturated level field and reaches the empty-read case. The automatic reseed fires after only 10 reads, so the bench can check both the 9th read, which must not trigger a reseed, and the 10th, which must. It then follows the old stream into the new one. The mask bits are swept through all four settings, once with done only and once with done plus an error pending.

// File: rtl/randgen_pkg.sv
package randgen_pkg;

    localparam int DATA_W = 32;

    // word indices of the registers
    localparam int IDX_VER  = 0;
    localparam int IDX_CMD  = 1;
    localparam int IDX_CTRL = 2;
    localparam int IDX_STAT = 3;
    localparam int IDX_ERR  = 4;
    localparam int IDX_DATA = 5;

    // bit positions
    localparam int CMD_TEST   = 0;
    localparam int CMD_SEED   = 1;
    localparam int CMD_CLRI   = 4;
    localparam int CMD_CLRE   = 5;
    localparam int CTL_AUTO   = 4;
    localparam int CTL_MDONE  = 5;
    localparam int CTL_MERR   = 6;
    localparam int STB_TDONE  = 4;
    localparam int STB_SDONE  = 5;
    localparam int STB_LVL    = 8;
    localparam int STB_ERR    = 16;
    localparam int ERB_STAT   = 3;
    localparam int LVL_MAX    = 15;

    localparam logic [DATA_W-1:0] LFSR_TAPS = 32'h8020_0003;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_TEST,
        SQ_SEED
    } seq_state_e;

    typedef struct packed {
        logic clr_err;
        logic clr_int;
        logic seed;
        logic test;
    } cmd_t;

    typedef struct packed {
        logic mask_err;
        logic mask_done;
        logic auto_seed;
    } ctrl_t;

    function automatic logic [DATA_W-1:0] lfsr_step(input logic [DATA_W-1:0] s);
        return {1'b0, s[DATA_W-1:1]} ^ (s[0] ? LFSR_TAPS : '0);
    endfunction

    function automatic cmd_t decode_cmd(input logic [DATA_W-1:0] w);
        cmd_t c;
        c.test    = w[CMD_TEST];
        c.seed    = w[CMD_SEED];
        c.clr_int = w[CMD_CLRI];
        c.clr_err = w[CMD_CLRE];
        return c;
    endfunction

    function automatic ctrl_t decode_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.auto_seed = w[CTL_AUTO];
        c.mask_done = w[CTL_MDONE];
        c.mask_err  = w[CTL_MERR];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] encode_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTL_AUTO]  = c.auto_seed;
        w[CTL_MDONE] = c.mask_done;
        w[CTL_MERR]  = c.mask_err;
        return w;
    endfunction

endpackage

// File: rtl/randgen_seq.sv
module randgen_seq
    import randgen_pkg::*;
#(
    parameter int ST_CYCLES   = 1000,
    parameter int SEED_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_test,
    input  logic start_seed,
    output logic busy,
    output logic test_fin,
    output logic seed_fin
);
    localparam int MAX_CYC = (ST_CYCLES > SEED_CYCLES) ? ST_CYCLES : SEED_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_state_e       state;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] run_len;

    assign busy     = (state != SQ_IDLE);
    assign test_fin = (state == SQ_TEST) && (cnt == '0);
    assign seed_fin = (state == SQ_SEED) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SQ_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                SQ_IDLE: begin
                    if (start_test) begin
                        state <= SQ_TEST;
                        cnt   <= CNT_W'(ST_CYCLES - 1);
                    end else if (start_seed) begin
                        state <= SQ_SEED;
                        cnt   <= CNT_W'(SEED_CYCLES - 1);
                    end
                end
                default: begin
                    if (cnt == '0) state <= SQ_IDLE;
                    else           cnt   <= cnt - 1'b1;
                end
            endcase
        end
    end

    // independent run-length counter used only by the checks below
    always_ff @(posedge clk) begin
        if (rst)       run_len <= '0;
        else if (busy) run_len <= run_len + 1'b1;
        else           run_len <= '0;
    end

    assert_test_len_R2: assert property (@(posedge clk) disable iff (rst)
        test_fin |-> (run_len == CNT_W'(ST_CYCLES - 1)));

    assert_seed_len_R2: assert property (@(posedge clk) disable iff (rst)
        seed_fin |-> (run_len == CNT_W'(SEED_CYCLES - 1)));

    assert_busy_ignore_R3: assert property (@(posedge clk) disable iff (rst)
        (busy && (start_test || start_seed) && !test_fin && !seed_fin)
            |=> (state == $past(state)));

endmodule

// File: rtl/randgen_lfsr.sv
module randgen_lfsr
    import randgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    input  logic              advance,
    output logic [DATA_W-1:0] word
);
    logic [DATA_W-1:0] state;

    assign word = lfsr_step(state);

    always_ff @(posedge clk) begin
        if (rst)          state <= {{(DATA_W-1){1'b0}}, 1'b1};
        else if (load)    state <= (load_val == '0) ? {{(DATA_W-1){1'b0}}, 1'b1} : load_val;
        else if (advance) state <= word;
    end

    assert_state_nonzero_R8: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/randgen_fifo.sv
module randgen_fifo
    import randgen_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [DATA_W-1:0]          push_data,
    input  logic                       pop,
    output logic [DATA_W-1:0]          head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign do_pop  = pop && (count != '0);
    assign do_push = push && (count != CNT_W'(DEPTH));
    assign head    = (count != '0) ? mem[rd_ptr] : '0;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        push |-> (count < CNT_W'(DEPTH)));

    assert_empty_read_R10: assert property (@(posedge clk) disable iff (rst)
        (pop && count == '0 && !push) |=> (count == '0));

endmodule

// File: rtl/randgen_ctrl.sv
module randgen_ctrl
    import randgen_pkg::*;
#(
    parameter int         ADDR_W          = 8,
    parameter int         FIFO_DEPTH      = 16,
    parameter int         ST_CYCLES       = 1000,
    parameter int         SEED_CYCLES     = 2000,
    parameter int         RESEED_BLOCKS   = 1 << 20,
    parameter int         WORDS_PER_BLOCK = 5,
    parameter logic [3:0] VER_TYPE        = 4'd2,
    parameter logic [7:0] VER_MAJ         = 8'd2,
    parameter logic [7:0] VER_MIN         = 8'd1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       entropy_in,
    input  logic              force_stat_err,
    output logic              irq
);
    localparam int IDX_W        = ADDR_W - 2;
    localparam int CNT_W        = $clog2(FIFO_DEPTH + 1);
    localparam int RESEED_WORDS = RESEED_BLOCKS * WORDS_PER_BLOCK;
    localparam int RC_W         = $clog2(RESEED_WORDS + 1);
    localparam logic [RC_W-1:0] RESEED_LAST = RC_W'(RESEED_WORDS - 1);

    logic [IDX_W-1:0]  widx;
    cmd_t              cmd;
    ctrl_t             ctrl;
    logic              cmd_wr, ctrl_wr, data_rd;
    logic              st_done, seed_done, stat_err, seeded;
    logic              err_any, done_any;
    logic              req_test, req_seed, seed_accept;
    logic              busy, test_fin, seed_fin;
    logic              reseed_pend;
    logic [RC_W-1:0]   served;
    logic              gen_push;
    logic [DATA_W-1:0] gen_word, fifo_head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [3:0]        lvl_field;
    logic [31:0]       ver_word, stat_word, err_word;

    assign widx    = bus_addr[ADDR_W-1:2];
    assign cmd     = decode_cmd(bus_wdata);
    assign cmd_wr  = bus_wr && (widx == IDX_W'(IDX_CMD));
    assign ctrl_wr = bus_wr && (widx == IDX_W'(IDX_CTRL));
    assign data_rd = bus_rd && (widx == IDX_W'(IDX_DATA));

    assign err_any  = stat_err;
    assign done_any = st_done || seed_done;

    // command acceptance, self test has priority over seeding
    assign req_test    = cmd_wr && cmd.test;
    assign req_seed    = (cmd_wr && cmd.seed) || reseed_pend;
    assign seed_accept = req_seed && !busy && !req_test;

    randgen_seq #(
        .ST_CYCLES  (ST_CYCLES),
        .SEED_CYCLES(SEED_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_test(req_test),
        .start_seed(req_seed),
        .busy      (busy),
        .test_fin  (test_fin),
        .seed_fin  (seed_fin)
    );

    assign gen_push = seeded && !busy && (fifo_cnt != CNT_W'(FIFO_DEPTH));

    randgen_lfsr u_lfsr (
        .clk     (clk),
        .rst     (rst),
        .load    (seed_fin && !force_stat_err),
        .load_val(entropy_in),
        .advance (gen_push),
        .word    (gen_word)
    );

    randgen_fifo #(
        .DEPTH(FIFO_DEPTH)
    ) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .push     (gen_push),
        .push_data(gen_word),
        .pop      (data_rd),
        .head     (fifo_head),
        .count    (fifo_cnt)
    );

    // flags, control and error state
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl      <= '0;
            st_done   <= 1'b0;
            seed_done <= 1'b0;
            stat_err  <= 1'b0;
            seeded    <= 1'b0;
        end else begin
            if (ctrl_wr) ctrl <= decode_ctrl(bus_wdata);
            if (cmd_wr && cmd.clr_err && err_any) begin
                stat_err  <= 1'b0;
                st_done   <= 1'b0;
                seed_done <= 1'b0;
            end else if (cmd_wr && cmd.clr_int && !err_any) begin
                st_done   <= 1'b0;
                seed_done <= 1'b0;
            end
            if (test_fin) st_done <= 1'b1;
            if (seed_fin) begin
                seed_done <= 1'b1;
                if (force_stat_err) begin
                    stat_err <= 1'b1;
                    seeded   <= 1'b0;
                end else begin
                    seeded   <= 1'b1;
                end
            end
        end
    end

    // served-word counting for automatic reseed
    always_ff @(posedge clk) begin
        if (rst) begin
            served      <= '0;
            reseed_pend <= 1'b0;
        end else begin
            if (seed_accept) reseed_pend <= 1'b0;
            if (data_rd && (fifo_cnt != '0) && ctrl.auto_seed) begin
                if (served == RESEED_LAST) begin
                    served      <= '0;
                    reseed_pend <= 1'b1;
                end else begin
                    served <= served + 1'b1;
                end
            end
        end
    end

    assign lvl_field = (int'(fifo_cnt) >= LVL_MAX) ? 4'(LVL_MAX) : 4'(fifo_cnt);

    always_comb begin
        ver_word         = '0;
        ver_word[31:28]  = VER_TYPE;
        ver_word[15:8]   = VER_MAJ;
        ver_word[7:0]    = VER_MIN;
        stat_word                    = '0;
        stat_word[STB_TDONE]         = st_done;
        stat_word[STB_SDONE]         = seed_done;
        stat_word[STB_LVL +: 4]      = lvl_field;
        stat_word[STB_ERR]           = err_any;
        err_word                     = '0;
        err_word[ERB_STAT]           = stat_err;
    end

    always_comb begin
        case (int'(widx))
            IDX_VER:  bus_rdata = ver_word;
            IDX_CTRL: bus_rdata = encode_ctrl(ctrl);
            IDX_STAT: bus_rdata = stat_word;
            IDX_ERR:  bus_rdata = err_word;
            IDX_DATA: bus_rdata = fifo_head;
            default:  bus_rdata = '0;
        endcase
    end

    assign irq = (done_any && !ctrl.mask_done) || (err_any && !ctrl.mask_err);

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (rst)
        irq |-> (st_done || seed_done || stat_err));

    assert_stat_err_R4: assert property (@(posedge clk) disable iff (rst)
        (seed_fin && force_stat_err) |=> (stat_err && !seeded));

    assert_clr_int_blocked_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd.clr_int && !cmd.clr_err && stat_err) |=> stat_err);

    assert_clr_err_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd.clr_err && stat_err && !seed_fin) |=> (!stat_err && !seed_done));

    assert_reseed_start_R11: assert property (@(posedge clk) disable iff (rst)
        (reseed_pend && !busy && !req_test) |=> busy);

    assert_no_gen_busy_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(fifo_cnt) || (fifo_cnt < $past(fifo_cnt)));

endmodule

// File: tb/randgen_ctrl_bench.sv
`timescale 1ns/1ps
module randgen_ctrl_bench;
    localparam int ST   = 40;
    localparam int SEED = 12;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] entropy_in = '0;
    logic        force_stat_err = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [31:0] exps;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    randgen_ctrl #(
        .ADDR_W(8), .FIFO_DEPTH(16), .ST_CYCLES(ST), .SEED_CYCLES(SEED),
        .RESEED_BLOCKS(2), .WORDS_PER_BLOCK(5),
        .VER_TYPE(4'd2), .VER_MAJ(8'h03), .VER_MIN(8'h15)
    ) u_randgen_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .entropy_in(entropy_in), .force_stat_err(force_stat_err), .irq(irq)
    );

    function automatic logic [31:0] step(input logic [31:0] s);
        return {1'b0, s[31:1]} ^ (s[0] ? 32'h8020_0003 : 32'h0);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        bus_addr  = 8'(idx * 4);
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input int idx, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 8'(idx * 4);
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic read_word(input string req);
        logic [31:0] d;
        rd(5, d);
        exps = step(exps);
        check(req, d, exps);
    endtask

    task automatic check_level(input string req, input int lvl);
        logic [31:0] d;
        rd(3, d);
        check(req, {28'h0, d[11:8]}, 32'(lvl));
    endtask

    task automatic check_bit(input string req, input int idx, input int b, input logic exp);
        logic [31:0] d;
        rd(idx, d);
        check(req, {31'h0, d[b]}, {31'h0, exp});
    endtask

    task automatic check_irq(input string req, input logic exp);
        @(negedge clk);
        #1 check(req, {31'h0, irq}, {31'h0, exp});
    endtask

    initial begin
        idle(4);
        @(negedge clk) rst = 1'b0;
        idle(1);

        // reset state
        rd(2, rv); check("R12 control", rv, 32'h0);
        rd(3, rv); check("R12 status", rv, 32'h0);
        rd(4, rv); check("R12 error", rv, 32'h0);
        check_irq("R12 irq", 1'b0);
        rd(0, rv); check("R1 version", rv, 32'h2000_0315);

        // empty read
        rd(5, rv); check("R10 empty data", rv, 32'h0);
        check_level("R10 empty level", 0);

        // self test
        wr(1, 32'h1);
        idle(5);
        check_bit("R2 test running", 3, 4, 1'b0);
        idle(ST);
        check_bit("R2 test done", 3, 4, 1'b1);
        check_irq("R7 irq on done", 1'b1);
        wr(1, 32'h10);
        check_bit("R5 clear int", 3, 4, 1'b0);
        check_irq("R5 irq cleared", 1'b0);

        // seed, then a self test while busy
        entropy_in = 32'hA5C3_0F17;
        wr(1, 32'h2);
        wr(1, 32'h1);
        idle(SEED + ST + 4);
        check_bit("R2 seed done", 3, 5, 1'b1);
        check_bit("R3 ignored test", 3, 4, 1'b0);
        idle(20);
        check_level("R9 full level saturates", 15);
        exps = 32'hA5C3_0F17;
        for (int i = 0; i < 5; i++) read_word("R8 stream after seed");

        // depth and empty read during a paused generator
        idle(20);
        wr(1, 32'h1);
        read_word("R8 stream during test");
        read_word("R8 stream during test");
        check_level("R9 depth is 16", 14);
        for (int i = 0; i < 14; i++) read_word("R8 drain");
        check_level("R9 drained", 0);
        rd(5, rv); check("R10 empty data in test", rv, 32'h0);
        check_level("R10 level after empty read", 0);
        idle(ST + 20);
        check_bit("R2 test done again", 3, 4, 1'b1);

        // clear-error without an error
        wr(1, 32'h20);
        check_bit("R6 no effect without error", 3, 4, 1'b1);
        check_bit("R6 seed flag kept", 3, 5, 1'b1);
        wr(1, 32'h10);
        check_bit("R5 clear done", 3, 5, 1'b0);

        // failed seed
        force_stat_err = 1'b1;
        wr(1, 32'h2);
        idle(SEED + 3);
        force_stat_err = 1'b0;
        rd(4, rv); check("R4 error reg", rv, 32'h8);
        check_bit("R4 status error", 3, 16, 1'b1);
        read_word("R4 old word");
        read_word("R4 old word");
        idle(5);
        check_level("R4 no refill", 14);
        wr(1, 32'h10);
        rd(4, rv); check("R5 error stays", rv, 32'h8);
        check_bit("R5 done stays", 3, 5, 1'b1);
        for (int m = 0; m < 4; m++) begin
            wr(2, 32'(m) << 5);
            rd(2, rv); check("R7 control readback", rv, 32'(m) << 5);
            check_irq("R7 irq err and done", (m != 3));
        end
        wr(2, 32'h0);
        wr(1, 32'h20);
        rd(4, rv); check("R6 error cleared", rv, 32'h0);
        rd(3, rv); check("R6 status cleared", {rv[16], rv[5], rv[4]} , 32'h0);
        check_irq("R6 irq low", 1'b0);

        // retry with new entropy
        entropy_in = 32'h0000_0000;
        wr(1, 32'h2);
        idle(SEED + 20);
        rd(4, rv); check("R4 retry ok", rv, 32'h0);
        for (int i = 0; i < 14; i++) read_word("R8 old words first");
        exps = 32'h1;
        for (int i = 0; i < 3; i++) read_word("R8 zero entropy loads one");

        // mask sweep with done only
        idle(20);
        for (int m = 0; m < 4; m++) begin
            wr(2, 32'(m) << 5);
            check_irq("R7 irq done only", (m[0] == 1'b0));
        end
        wr(1, 32'h10);

        // automatic reseed
        entropy_in = 32'h1357_9BDF;
        wr(2, 32'h10);
        for (int i = 0; i < 9; i++) begin
            read_word("R11 before reseed");
            idle(2);
        end
        idle(SEED + 5);
        check_bit("R11 no reseed at 9", 3, 5, 1'b0);
        read_word("R11 tenth word");
        idle(SEED + 20);
        check_bit("R11 reseed done", 3, 5, 1'b1);
        wr(2, 32'h0);
        for (int i = 0; i < 16; i++) read_word("R11 old words kept");
        exps = 32'h1357_9BDF;
        for (int i = 0; i < 3; i++) read_word("R11 new stream");

        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule